// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable model of the device side of a three-wire serial nonvolatile memory. A host drives chip select, a serial clock and a data input, and reads a data output that the block drives only when it has something to say. The output comes with an enable so that a tri-state pad can be built around it. The block holds 8192 bits in an on-chip register array. An organization input chooses at run time whether that storage is seen as 1024 bytes or as 512 sixteen-bit words.

Every command starts with a 1 bit, followed by a two-bit opcode and an address field. Writes also carry a data field. Reads stream data back and keep going through the address space for as long as the host keeps clocking. Program and erase operations arm a self-timed cycle. That cycle starts only when chip select drops inside a narrow window. While the cycle runs, the block reports busy or ready on the data output whenever it is selected.

The serial pins are brought into the system clock domain through synchronizers, and their edges are detected there. The length of a program cycle is a parameter counted in system clocks. Bulk operations walk the array one byte per system clock.

Top module: `seep_slave`

## Requirements
- R1: After reset the output enable is low, the write-enable latch is clear, and no cycle is running, so selecting the device drives nothing.
- R2: A command is a 1 start bit, a two-bit opcode (10 read, 01 write, 11 erase, 00 special) and an address field, all sampled at synchronized rising serial-clock edges, MSB first. The address field is 11 bits when the byte organization is selected and 10 bits when the word organization is selected. Its most significant bit is clocked in but ignored.
- R3: After the last address bit of a read, the output is enabled and shows a 0. Each following rising edge presents the next bit of the addressed item, MSB first.
- R4: While chip select stays high, the read continues with the next location after each item, without any further leading 0, and it wraps from the last location to location 0.
- R5: With opcode 00, the top two address bits select the special command: 11 sets the write-enable latch, 00 clears it. While the latch is clear, write, erase, erase-all and write-all change nothing and start no cycle.
- R6: A write stores its data field (16 bits for words, 8 for bytes, MSB first) at the addressed location, with no erase needed beforehand.
- R7: An erase sets the addressed location to all ones.
- R8: Erase-all (special 10) sets every location to all ones. Write-all (special 01, followed by a data field) stores its data in every location.
- R9: A program or erase cycle starts only when chip select falls after the last bit of the command and before the next rising serial edge. An extra rising edge discards the command.
- R10: Once a cycle has started, selecting the device enables the output: 0 while busy, 1 when ready. After a 1 is clocked in, the output turns off at the next falling serial edge.
- R11: Commands that arrive during a running cycle are ignored.
- R12: Chip select low turns the output off and drops any partly received command or running read.
- R13: In the word organization, word a occupies bytes 2a (upper half) and 2a+1 (lower half) of the byte organization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high, asynchronous to clk |
| sclk_i | input | 1 | Serial clock from the host |
| din_i | input | 1 | Serial data from the host |
| org_wide_i | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| dout_o | output | 1 | Serial data and status to the host |
| dout_oe_o | output | 1 | Output enable for the data pad |

## Verification
The assertions assume that every serial pin stays stable for several system clocks around each serial edge. This keeps the synchronized clock, data and select aligned. They also assume that chip select never changes in the same system cycle as a serial edge, and that the organization input is held for the whole of a command. The stimulus guarantees this: it changes data two system clocks before each rising edge, keeps both serial phases eight clocks long, and waits several clocks after moving chip select before the next edge. It sets the organization only while the device is deselected.

// File: rtl/seep_pkg.sv
package seep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_ARMED,
        ST_READ,
        ST_HOLD
    } seep_state_e;

    typedef enum logic [1:0] {
        K_WRITE,
        K_ERASE,
        K_WRALL,
        K_ERALL
    } seep_kind_e;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] SUB_WEN   = 2'b11;
    localparam logic [1:0] SUB_WDIS  = 2'b00;
    localparam logic [1:0] SUB_ERALL = 2'b10;

endpackage

// File: rtl/seep_sync.sv
module seep_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o
);
    logic [STAGES-1:0][N-1:0] st_d, st_q;

    if (STAGES == 1) begin : g_one
        assign st_d = async_i;
    end else begin : g_chain
        assign st_d = {st_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o = st_q[STAGES-1];
endmodule

// File: rtl/seep_timer.sv
module seep_timer #(
    parameter int CYCLE_CLKS = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int TW = $clog2(CYCLE_CLKS + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)             cnt_d = TW'(CYCLE_CLKS);
        else if (cnt_q != '0)    cnt_d = cnt_q - TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
endmodule

// File: rtl/seep_array.sv
module seep_array #(
    parameter int BYTES = 1024,
    localparam int BA   = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [BA-1:0] base_i,
    input  logic [BA:0]   count_i,
    input  logic          erase_i,
    input  logic          wide_i,
    input  logic [15:0]   data_i,
    input  logic [BA-1:0] rd_a_i,
    input  logic [BA-1:0] rd_b_i,
    output logic [7:0]    byte_a_o,
    output logic [7:0]    byte_b_o,
    output logic          active_o
);
    typedef struct packed {
        logic [BA-1:0] ptr;
        logic [BA:0]   left;
        logic          erase;
        logic          wide;
        logic [15:0]   data;
    } sweep_t;

    sweep_t     d, q;
    logic [7:0] mem_q [BYTES];
    logic [7:0] wval;
    logic       we;

    always_comb begin
        d    = q;
        we   = (q.left != '0);
        wval = q.erase ? 8'hFF
             : (q.wide && !q.ptr[0]) ? q.data[15:8] : q.data[7:0];
        if (start_i) begin
            d.ptr   = base_i;
            d.left  = count_i;
            d.erase = erase_i;
            d.wide  = wide_i;
            d.data  = data_i;
        end else if (we) begin
            d.ptr  = q.ptr + BA'(1);
            d.left = q.left - (BA+1)'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (we) mem_q[q.ptr] <= wval;
    end

    assign byte_a_o = mem_q[rd_a_i];
    assign byte_b_o = mem_q[rd_b_i];
    assign active_o = we;

    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (q.left == '0));
endmodule

// File: rtl/seep_slave.sv
module seep_slave #(
    parameter int MEM_BITS    = 8192,
    parameter int CYCLE_CLKS  = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic din_i,
    input  logic org_wide_i,
    output logic dout_o,
    output logic dout_oe_o
);
    import seep_pkg::*;

    localparam int BYTES = MEM_BITS / 8;
    localparam int BA    = $clog2(BYTES);
    localparam int SH_W  = BA + 2;
    localparam int CW    = $clog2(BA + 17);

    typedef struct packed {
        seep_state_e     state;
        seep_kind_e      kind;
        logic [SH_W-1:0] sh;
        logic [CW-1:0]   cnt;
        logic [BA-1:0]   addr;
        logic [15:0]     data;
        logic [15:0]     osh;
        logic [4:0]      rd_left;
        logic            wen;
        logic            stat;
        logic            hz_pend;
        logic            dout;
        logic            oe;
        logic            cs_p;
        logic            sclk_p;
    } core_t;

    core_t d, q;

    logic [2:0]    lvl;
    logic          cs_s, sclk_s, din_s, sclk_r, sclk_f, cs_f;
    logic          wide, launch, busy, tmr_busy, arr_busy;
    logic [SH_W:0] nsh;
    logic [1:0]    op, sub;
    logic [BA-1:0] loc, rd_a, rd_b, wbase, next_addr;
    logic [BA:0]   wcount;
    logic [CW-1:0] hdr_last, dat_last;
    logic [7:0]    byte_a, byte_b;
    logic [15:0]   word;
    logic          bulk, erase_op;

    seep_sync #(.N(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_i, sclk_i, din_i}),
        .lvl_o   (lvl)
    );

    assign cs_s   = lvl[2];
    assign sclk_s = lvl[1];
    assign din_s  = lvl[0];
    assign sclk_r = sclk_s & ~q.sclk_p;
    assign sclk_f = ~sclk_s & q.sclk_p;
    assign cs_f   = ~cs_s & q.cs_p;
    assign wide   = org_wide_i;
    assign busy   = tmr_busy | arr_busy;

    always_comb begin
        d        = q;
        launch   = 1'b0;
        d.cs_p   = cs_s;
        d.sclk_p = sclk_s;
        nsh      = {q.sh, din_s};
        hdr_last = wide ? CW'(BA + 1) : CW'(BA + 2);
        dat_last = wide ? CW'(15) : CW'(7);
        if (wide) begin
            op  = nsh[BA+1:BA];
            sub = nsh[BA-1:BA-2];
            loc = {1'b0, nsh[BA-2:0]};
        end else begin
            op  = nsh[BA+2:BA+1];
            sub = nsh[BA:BA-1];
            loc = nsh[BA-1:0];
        end
        rd_a      = wide ? {q.addr[BA-2:0], 1'b0} : q.addr;
        rd_b      = {q.addr[BA-2:0], 1'b1};
        word      = wide ? {byte_a, byte_b} : {byte_a, 8'h00};
        next_addr = wide ? {1'b0, q.addr[BA-2:0] + (BA-1)'(1)} : q.addr + BA'(1);

        if (q.hz_pend && sclk_f) begin
            d.hz_pend = 1'b0;
            d.stat    = 1'b0;
            d.oe      = 1'b0;
        end

        if (!cs_s) begin
            if (q.hz_pend) d.stat = 1'b0;
            if (q.state == ST_ARMED && cs_f && q.wen && !busy) begin
                launch = 1'b1;
                d.stat = 1'b1;
            end
            d.state   = ST_IDLE;
            d.oe      = 1'b0;
            d.hz_pend = 1'b0;
        end else begin
            unique case (q.state)
                ST_IDLE: begin
                    if (q.stat && !q.hz_pend) begin
                        d.oe   = 1'b1;
                        d.dout = ~busy;
                    end
                    if (sclk_r && din_s && !busy) begin
                        d.state   = ST_HDR;
                        d.cnt     = '0;
                        d.hz_pend = q.stat;
                    end
                end
                ST_HDR: if (sclk_r) begin
                    d.sh  = nsh[SH_W-1:0];
                    d.cnt = q.cnt + CW'(1);
                    if (q.cnt == hdr_last) begin
                        d.addr = loc;
                        d.cnt  = '0;
                        case (op)
                            OP_READ: begin
                                d.state   = ST_READ;
                                d.oe      = 1'b1;
                                d.dout    = 1'b0;
                                d.rd_left = '0;
                            end
                            OP_WRITE: begin d.state = ST_DATA;  d.kind = K_WRITE; end
                            OP_ERASE: begin d.state = ST_ARMED; d.kind = K_ERASE; end
                            default: case (sub)
                                SUB_WEN:   begin d.wen = 1'b1; d.state = ST_HOLD; end
                                SUB_WDIS:  begin d.wen = 1'b0; d.state = ST_HOLD; end
                                SUB_ERALL: begin d.state = ST_ARMED; d.kind = K_ERALL; end
                                default:   begin d.state = ST_DATA;  d.kind = K_WRALL; end
                            endcase
                        endcase
                    end
                end
                ST_DATA: if (sclk_r) begin
                    d.data = {q.data[14:0], din_s};
                    d.cnt  = q.cnt + CW'(1);
                    if (q.cnt == dat_last) d.state = ST_ARMED;
                end
                ST_ARMED: if (sclk_r) d.state = ST_HOLD;
                ST_READ: if (sclk_r) begin
                    if (q.rd_left == '0) begin
                        d.dout    = word[15];
                        d.osh     = {word[14:0], 1'b0};
                        d.rd_left = wide ? 5'd15 : 5'd7;
                        d.addr    = next_addr;
                    end else begin
                        d.dout    = q.osh[15];
                        d.osh     = {q.osh[14:0], 1'b0};
                        d.rd_left = q.rd_left - 5'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bulk     = (q.kind == K_WRALL) || (q.kind == K_ERALL);
    assign erase_op = (q.kind == K_ERASE) || (q.kind == K_ERALL);
    assign wbase    = bulk ? '0 : (wide ? {q.addr[BA-2:0], 1'b0} : q.addr);
    assign wcount   = bulk ? (BA+1)'(BYTES) : (wide ? (BA+1)'(2) : (BA+1)'(1));

    seep_timer #(.CYCLE_CLKS(CYCLE_CLKS)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (launch),
        .busy_o  (tmr_busy)
    );

    seep_array #(.BYTES(BYTES)) array_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (launch),
        .base_i   (wbase),
        .count_i  (wcount),
        .erase_i  (erase_op),
        .wide_i   (wide),
        .data_i   (q.data),
        .rd_a_i   (rd_a),
        .rd_b_i   (rd_b),
        .byte_a_o (byte_a),
        .byte_b_o (byte_b),
        .active_o (arr_busy)
    );

    assign dout_o    = q.dout;
    assign dout_oe_o = q.oe;

    // R12
    oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !dout_oe_o);

    // R9
    busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(launch));

    // R5
    wen_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.wen) |-> $past(sclk_r));

    // R3
    rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_READ && cs_s) |-> dout_oe_o);
endmodule

// File: tb/seep_slave_tb_top.sv
module seep_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int CYC        = 40;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, din = 1'b0, wide = 1'b1;
    logic dout, oe;
    int   total = 0, bad = 0;
    bit   wen_m = 1'b0;
    logic [7:0] mem_m [1024];
    logic  exp_v [$];
    string exp_t [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    seep_slave #(.MEM_BITS(8192), .CYCLE_CLKS(CYC), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .din_i(din),
        .org_wide_i(wide), .dout_o(dout), .dout_oe_o(oe)
    );

    task automatic check(input logic act, input logic expv, input string req, input string what);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, expv);
        end
    endtask

    // monitor: pops one expected bit per rising serial edge
    initial forever begin
        @(posedge sclk);
        if (exp_v.size() > 0) begin
            logic  ev;
            string et;
            ev = exp_v.pop_front();
            et = exp_t.pop_front();
            repeat (6) @(negedge clk);
            check(oe, 1'b1, et, "output enable");
            check(dout, ev, et, "serial bit");
        end
    end

    task automatic tick(input int n); repeat (n) @(negedge clk); endtask
    task automatic sbit(input logic b); din = b; tick(2); sclk = 1'b1; tick(HALF); sclk = 1'b0; tick(HALF); endtask
    task automatic sel(); cs = 1'b1; tick(4); endtask
    task automatic desel(); cs = 1'b0; din = 1'b0; tick(6); endtask
    function automatic int abits(input bit w); return w ? 10 : 11; endfunction
    function automatic int amask(input bit w, input int a); return w ? (a & 511) : (a & 1023); endfunction

    task automatic hdr(input bit w, input logic [1:0] op, input int a, input bit mark, input string tag);
        sbit(1'b1); sbit(op[1]); sbit(op[0]);
        for (int i = abits(w) - 1; i >= 0; i--) begin
            if (i == 0 && mark) begin exp_v.push_back(1'b0); exp_t.push_back(tag); end
            sbit(a[i]);
        end
    endtask

    task automatic send_data(input bit w, input logic [15:0] v);
        for (int i = (w ? 15 : 7); i >= 0; i--) sbit(v[i]);
    endtask

    task automatic m_store(input bit w, input int a, input logic [15:0] v);
        if (w) begin mem_m[amask(1, a)*2] = v[15:8]; mem_m[amask(1, a)*2+1] = v[7:0]; end
        else mem_m[amask(0, a)] = v[7:0];
    endtask

    task automatic do_write(input bit w, input int a, input logic [15:0] v, input bit in_window);
        wide = w; sel(); hdr(w, 2'b01, a, 1'b0, ""); send_data(w, v);
        if (!in_window) sbit(1'b0);
        desel();
        if (in_window && wen_m) m_store(w, a, v);
    endtask

    task automatic do_erase(input bit w, input int a);
        wide = w; sel(); hdr(w, 2'b11, a, 1'b0, ""); desel();
        if (wen_m) m_store(w, a, 16'hFFFF);
    endtask

    task automatic do_spec(input bit w, input logic [1:0] sub, input logic [15:0] v);
        wide = w; sel(); hdr(w, 2'b00, int'(sub) << (abits(w) - 2), 1'b0, "");
        if (sub == 2'b01) send_data(w, v);
        desel();
        case (sub)
            2'b11: wen_m = 1'b1;
            2'b00: wen_m = 1'b0;
            2'b10: if (wen_m) for (int i = 0; i < 1024; i++) mem_m[i] = 8'hFF;
            default: if (wen_m) for (int i = 0; i < 512; i++) m_store(1'b1, i, v);
        endcase
    endtask

    task automatic do_read(input bit w, input int a, input int n, input string tag);
        int idx;
        wide = w; sel(); hdr(w, 2'b10, a, 1'b1, "R3");
        idx = amask(w, a);
        for (int k = 0; k < n; k++) begin
            logic [15:0] ev;
            ev = w ? {mem_m[idx*2], mem_m[idx*2+1]} : {8'h00, mem_m[idx]};
            for (int b = (w ? 15 : 7); b >= 0; b--) begin
                exp_v.push_back(ev[b]); exp_t.push_back(tag);
                sbit(1'b0);
            end
            idx = w ? ((idx + 1) & 511) : ((idx + 1) & 1023);
        end
        desel();
    endtask

    task automatic wait_ready(input string tag);
        int n;
        sel();
        n = 0;
        while (!(oe === 1'b1 && dout === 1'b1) && n < 6000) begin tick(1); n++; end
        total++;
        if (n >= 6000) begin bad++; $display("FAIL %s ready: actual busy expected ready", tag); end
        desel();
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        total++; bad++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem_m[i] = 8'h00;
        tick(5); rst_n = 1'b1; tick(5);

        // R1: reset state
        check(oe, 1'b0, "R1", "oe after reset");
        sel(); tick(6); check(oe, 1'b0, "R1", "selected idle drives nothing"); desel();

        // R5: write with latch clear starts nothing
        do_write(1'b0, 5, 16'h003C, 1'b1);
        sel(); tick(6); check(oe, 1'b0, "R5", "no cycle without enable"); desel();

        // R8 / R10: enable, erase all, status
        do_spec(1'b1, 2'b11, 16'h0000);
        do_spec(1'b1, 2'b10, 16'h0000);
        sel(); tick(6);
        check(oe, 1'b1, "R10", "status driven");
        check(dout, 1'b0, "R10", "busy shows 0");
        desel();
        wait_ready("R10");
        sel(); tick(6); check(dout, 1'b1, "R10", "ready shows 1");
        din = 1'b1; tick(2); sclk = 1'b1; tick(6);
        check(oe, 1'b1, "R10", "held until falling edge");
        sclk = 1'b0; tick(6);
        check(oe, 1'b0, "R10", "released at falling edge");
        desel();
        do_read(1'b0, 5, 1, "R8");

        // R6 / R13 / R4
        do_write(1'b1, 3, 16'hA55A, 1'b1); wait_ready("R6");
        do_read(1'b1, 3, 1, "R6");
        do_read(1'b0, 6, 2, "R13");
        do_write(1'b0, 1023, 16'h0012, 1'b1); wait_ready("R6");
        do_write(1'b0, 0, 16'h0034, 1'b1); wait_ready("R6");
        do_read(1'b0, 1023, 2, "R4");
        do_read(1'b1, 511, 2, "R4");

        // R2: top address bit ignored
        do_write(1'b0, 1024 + 9, 16'h0077, 1'b1); wait_ready("R2");
        do_read(1'b0, 9, 1, "R2");

        // R7: erase of byte 6 clears upper half of word 3
        do_erase(1'b0, 6); wait_ready("R7");
        do_read(1'b1, 3, 1, "R7");

        // R9: extra edge before deselect discards the write
        do_write(1'b1, 4, 16'h1111, 1'b0);
        sel(); tick(6); check(oe, 1'b0, "R9", "no cycle after late deselect"); desel();
        do_read(1'b1, 4, 1, "R9");

        // R11: write all, then a read while busy is ignored
        do_spec(1'b1, 2'b01, 16'hBEEF);
        wide = 1'b1; sel(); hdr(1'b1, 2'b10, 100, 1'b0, "");
        check(oe, 1'b1, "R11", "still status");
        check(dout, 1'b0, "R11", "read ignored while busy");
        desel();
        wait_ready("R8");
        do_read(1'b1, 100, 1, "R8");
        do_read(1'b0, 201, 1, "R8");

        // R5: disable then erase changes nothing
        do_spec(1'b1, 2'b00, 16'h0000);
        do_erase(1'b1, 100);
        sel(); tick(6); check(oe, 1'b0, "R5", "no cycle after disable"); desel();
        do_read(1'b1, 100, 1, "R5");

        // R12: abort a running read and a partial header
        wide = 1'b1; sel(); hdr(1'b1, 2'b10, 100, 1'b1, "R3");
        for (int b = 15; b >= 11; b--) begin
            logic [15:0] pv;
            pv = 16'hBEEF;
            exp_v.push_back(pv[b]); exp_t.push_back("R12");
            sbit(1'b0);
        end
        desel();
        check(oe, 1'b0, "R12", "oe off after deselect");
        sel(); sbit(1'b1); sbit(1'b1); desel();
        do_read(1'b0, 6, 1, "R12");

        tick(20);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule